// File: doc/BRIEF.md
# Video Character RAM Bus Bridge

This block is the glue between an asynchronous 32-bit processor bus and a shared byte-wide character memory that a video scan engine reads in parallel. The processor reaches the memory through one 4 KiB address window and reaches a pair of read-only keyboard registers through a second 4 KiB window. The block decodes both windows, stores processor writes, returns read data and drives a data-acknowledge handshake, but only for the memory window. The keyboard window completes without an acknowledge.

The processor-side memory address is presented to the array with its three address nibbles in reverse order. The video port applies the same reordering to its own linear address, so that processor location N and video location N always name the same byte. The scan engine sees a plain linear 12-bit address space. The keyboard deserializer and the pixel timing logic live elsewhere: keyboard data and status arrive here as plain byte inputs.

All inputs are taken as synchronous to `clk`. A bus cycle starts on the falling edge of the data strobe, as seen at a rising clock edge.

Top module: `vidram_bridge`

## Requirements
- R1: While reset is held and after it is released, with the strobe high, `cpu_ack_n` is 1 and `cpu_drive_en` is 0.
- R2: The memory window is addresses 0xFFFFD000 to 0xFFFFDFFF, and it is active only while `cs_mem_n` is 0. A write (`cpu_rw`=0) there stores `cpu_wdata` at the first clock edge after the strobe falls. A write with `cs_mem_n` high stores nothing.
- R3: In the memory window, `cpu_ack_n` goes to 0 at the first clock edge after the strobe falls, and not earlier.
- R4: `cpu_ack_n` returns to 1 at the first clock edge at which the strobe is seen high.
- R5: Accesses in the I/O window (0xFFFFC000 to 0xFFFFCFFF with `cs_io_n` 0) never drive `cpu_ack_n` to 0.
- R6: A read in the I/O window returns `kbd_data` at offset 0x0F4, `kbd_status` at offset 0x0F5 and 0x00 at any other offset. `cpu_rdata` is valid from the first clock edge after the strobe falls.
- R7: A write in the I/O window, including the two keyboard offsets, changes no memory byte.
- R8: `cpu_drive_en` is 1 only while the strobe is low, `cpu_rw` is 1, and either window is selected.
- R9: `ram_oe_n` is always the inverse of `cpu_rw`.
- R10: The processor-side array address `ram_addr` equals {A[3:0], A[7:4], A[11:8]}, from high nibble to low nibble.
- R11: A read in the memory window returns the byte last written at that address.
- R12: `vid_data` shows the byte at linear processor location `vid_addr` one clock edge after `vid_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 32 | Processor address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_ds_n | input | 1 | Data strobe, active low |
| cs_mem_n | input | 1 | Memory-window select, active low |
| cs_io_n | input | 1 | I/O-window select, active low |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_rdata | output | 8 | Read data to the processor |
| cpu_drive_en | output | 1 | Enables the data-bus drivers toward the processor |
| cpu_ack_n | output | 1 | Data acknowledge, active low |
| ram_oe_n | output | 1 | Array output enable, active low |
| ram_addr | output | 12 | Processor-side physical array address |
| kbd_data | input | 8 | Keyboard scan byte |
| kbd_status | input | 8 | Keyboard status byte |
| vid_addr | input | 12 | Linear video read address |
| vid_data | output | 8 | Video read data |

## Verification
If the two address reorderings disagree, then after a full write of the processor space some video reads return a byte that belongs to another location. A full sweep exposes this within one pass of 4096 reads. A stuck or mis-timed acknowledge register shows at the first clock edge after a strobe edge, either as a missing low pulse in the memory window or as a stray one in the I/O window. A decode fault shows as a keyboard value in place of a memory byte, or as a memory byte that changes after an ignored write. Random mixed traffic is checked against a bench memory model.

// File: rtl/vrb_pkg.sv
// Package: vrb_pkg
// Shared sizes and the address lane reordering used on both array ports.
// Assumes the array address width is a whole number of lanes.
package vrb_pkg;
    parameter int unsigned ADDR_W = 12;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned LANE_W = 4;
    localparam int unsigned LANES = ADDR_W / LANE_W;

    // Reverse lane order: lowest input lane becomes the highest output lane.
    function automatic logic [ADDR_W-1:0] lane_swap(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = a[(LANES-1-i)*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/vrb_decode.sv
// Module: vrb_decode
// Decodes the memory and I/O windows and the two keyboard offsets.
// Assumes each window is 2**ADDR_W bytes and aligned to its size.
module vrb_decode
    import vrb_pkg::*;
#(
    parameter logic [31:0]       MEM_BASE = 32'hFFFF_D000,
    parameter logic [31:0]       IO_BASE  = 32'hFFFF_C000,
    parameter logic [ADDR_W-1:0] KDAT_OFS = 12'h0F4,
    parameter logic [ADDR_W-1:0] KSTS_OFS = 12'h0F5
) (
    input  logic [31:0] addr,
    input  logic        cs_mem_n,
    input  logic        cs_io_n,
    output logic        mem_hit,
    output logic        io_hit,
    output logic        kdat_hit,
    output logic        ksts_hit
);
    localparam int unsigned TAG_W = 32 - ADDR_W;

    // Window match on the upper address bits, qualified by the select lines.
    always_comb begin
        mem_hit  = !cs_mem_n && (addr[31 -: TAG_W] == MEM_BASE[31 -: TAG_W]);
        io_hit   = !cs_io_n  && (addr[31 -: TAG_W] == IO_BASE[31 -: TAG_W]);
        kdat_hit = io_hit && (addr[ADDR_W-1:0] == KDAT_OFS);
        ksts_hit = io_hit && (addr[ADDR_W-1:0] == KSTS_OFS);
    end
endmodule

// File: rtl/vrb_dpram.sv
// Module: vrb_dpram
// Byte array with one write/async-read port for the processor and one
// registered read port for video. Assumes both ports use the same clock.
module vrb_dpram
    import vrb_pkg::*;
(
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Processor-side write.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
    end

    // Processor-side read, combinational.
    assign a_rdata = mem[a_addr];

    // Video-side registered read.
    always_ff @(posedge clk) begin
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/vrb_cpu_port.sv
// Module: vrb_cpu_port
// Strobe edge detection, write enable, acknowledge and read-data return.
// Assumes the strobe and the decode results are synchronous to clk.
module vrb_cpu_port
    import vrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              mem_hit,
    input  logic              io_hit,
    input  logic              kdat_hit,
    input  logic              ksts_hit,
    input  logic [DATA_W-1:0] kbd_data,
    input  logic [DATA_W-1:0] kbd_status,
    input  logic [DATA_W-1:0] ram_q,
    output logic              ram_we,
    output logic              ack_n,
    output logic [DATA_W-1:0] rdata,
    output logic              drive_en
);
    logic ds_prev;
    logic start;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ds_prev <= 1'b1;
        else        ds_prev <= ds_n;
    end

    // A cycle starts when the strobe falls; memory writes fire on that cycle only.
    always_comb begin
        start    = ds_prev && !ds_n;
        ram_we   = start && mem_hit && !rw;
        drive_en = !ds_n && rw && (mem_hit || io_hit);
    end

    // Acknowledge: set after a memory-window start, cleared when strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                ack_n <= 1'b1;
        else if (ds_n)             ack_n <= 1'b1;
        else if (start && mem_hit) ack_n <= 1'b0;
    end

    // Read-data return, refreshed while a read strobe is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (!ds_n && rw) begin
            if (mem_hit)       rdata <= ram_q;
            else if (kdat_hit) rdata <= kbd_data;
            else if (ksts_hit) rdata <= kbd_status;
            else               rdata <= '0;
        end
    end

    a_r3_ack_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mem_hit) |=> !ack_n);
    a_r4_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        ds_n |=> ack_n);
    a_r5_io_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && io_hit && ack_n) |=> ack_n);
endmodule

// File: rtl/vidram_bridge.sv
// Module: vidram_bridge
// Top level: window decode, lane reordering on both array ports, array and
// processor handshake. Assumes all inputs are synchronous to clk.
module vidram_bridge
    import vrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_ds_n,
    input  logic              cs_mem_n,
    input  logic              cs_io_n,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_drive_en,
    output logic              cpu_ack_n,
    output logic              ram_oe_n,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] kbd_data,
    input  logic [DATA_W-1:0] kbd_status,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [DATA_W-1:0] vid_data
);
    logic              mem_hit, io_hit, kdat_hit, ksts_hit;
    logic              ram_we;
    logic [DATA_W-1:0] ram_q;
    logic [ADDR_W-1:0] vid_phys;

    // Lane reordering on both ports, and output enable from R/W.
    always_comb begin
        ram_addr = lane_swap(cpu_addr[ADDR_W-1:0]);
        vid_phys = lane_swap(vid_addr);
        ram_oe_n = !cpu_rw;
    end

    vrb_decode u_decode (
        .addr     (cpu_addr),
        .cs_mem_n (cs_mem_n),
        .cs_io_n  (cs_io_n),
        .mem_hit  (mem_hit),
        .io_hit   (io_hit),
        .kdat_hit (kdat_hit),
        .ksts_hit (ksts_hit)
    );

    vrb_dpram u_ram (
        .clk     (clk),
        .a_we    (ram_we),
        .a_addr  (ram_addr),
        .a_wdata (cpu_wdata),
        .a_rdata (ram_q),
        .b_addr  (vid_phys),
        .b_rdata (vid_data)
    );

    vrb_cpu_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .ds_n       (cpu_ds_n),
        .rw         (cpu_rw),
        .mem_hit    (mem_hit),
        .io_hit     (io_hit),
        .kdat_hit   (kdat_hit),
        .ksts_hit   (ksts_hit),
        .kbd_data   (kbd_data),
        .kbd_status (kbd_status),
        .ram_q      (ram_q),
        .ram_we     (ram_we),
        .ack_n      (cpu_ack_n),
        .rdata      (cpu_rdata),
        .drive_en   (cpu_drive_en)
    );

    a_r3_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack_n |-> $past(!cpu_ds_n));
    a_r2_no_write_without_select: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mem_n && !cpu_ds_n) |-> !ram_we);
endmodule

// File: tb/vidram_bridge_tb_top.sv
// Bench: vidram_bridge_tb_top
// Full-space write and video readback, then seeded random mixed traffic
// with directed corners, checked against a bench memory model.
module vidram_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cpu_addr;
    logic        cpu_rw, cpu_ds_n, cs_mem_n, cs_io_n;
    logic [7:0]  cpu_wdata, cpu_rdata, kbd_data, kbd_status, vid_data;
    logic        cpu_drive_en, cpu_ack_n, ram_oe_n;
    logic [11:0] ram_addr, vid_addr;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [7:0] model [4096];

    always #4 clk = ~clk;

    vidram_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_ds_n(cpu_ds_n), .cs_mem_n(cs_mem_n), .cs_io_n(cs_io_n),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_drive_en(cpu_drive_en),
        .cpu_ack_n(cpu_ack_n), .ram_oe_n(ram_oe_n), .ram_addr(ram_addr),
        .kbd_data(kbd_data), .kbd_status(kbd_status), .vid_addr(vid_addr),
        .vid_data(vid_data)
    );

    function automatic logic [7:0] pattern(input int n);
        return 8'((n * 37) ^ ((n >> 4) * 11) ^ ((n >> 8) * 101) ^ 8'h5A);
    endfunction

    function automatic logic [11:0] phys(input logic [11:0] a);
        return {a[3:0], a[7:4], a[11:8]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle; mem selects the window, sel=0 leaves both selects high.
    task automatic bus(input logic [31:0] a, input logic rd, input logic [7:0] wd,
                       input bit mem, input bit sel, output logic [7:0] rdv);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rd; cpu_wdata = wd;
        cs_mem_n = !(sel && mem); cs_io_n = !(sel && !mem); cpu_ds_n = 1'b0;
        #1;
        chk(ram_oe_n == !rd, "R9 oe", ram_oe_n, !rd);
        chk(cpu_drive_en == (rd && sel), "R8 drive", cpu_drive_en, rd && sel);
        chk(cpu_ack_n == 1'b1, "R3 not early", cpu_ack_n, 1);
        chk(ram_addr == phys(a[11:0]), "R10 lanes", ram_addr, phys(a[11:0]));
        @(negedge clk);
        chk(cpu_ack_n == !(mem && sel), mem ? "R3 ack" : "R5 io no ack", cpu_ack_n, !(mem && sel));
        rdv = cpu_rdata;
        cpu_ds_n = 1'b1; cs_mem_n = 1'b1; cs_io_n = 1'b1;
        @(negedge clk);
        chk(cpu_ack_n == 1'b1, "R4 release", cpu_ack_n, 1);
        chk(cpu_drive_en == 1'b0, "R8 idle", cpu_drive_en, 0);
    endtask

    task automatic vid_check(input logic [11:0] n, input string req);
        @(negedge clk);
        vid_addr = n;
        @(negedge clk);
        chk(vid_data == model[n], req, vid_data, model[n]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd20240607));
        rst_n = 1'b0; cpu_addr = '0; cpu_rw = 1'b1; cpu_ds_n = 1'b1;
        cs_mem_n = 1'b1; cs_io_n = 1'b1; cpu_wdata = '0;
        kbd_data = 8'h00; kbd_status = 8'h00; vid_addr = '0;
        repeat (4) @(negedge clk);
        chk(cpu_ack_n == 1'b1, "R1 reset ack", cpu_ack_n, 1);
        chk(cpu_drive_en == 1'b0, "R1 reset drive", cpu_drive_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ack_n == 1'b1 && cpu_drive_en == 1'b0, "R1 after reset", cpu_ack_n, 1);

        // Fill the whole window, then sweep it through the video port.
        for (int n = 0; n < 4096; n++) begin
            model[n] = pattern(n);
            bus(32'hFFFF_D000 + n, 1'b0, model[n], 1'b1, 1'b1, rv);
        end
        for (int n = 0; n < 4096; n++) vid_check(12'(n), "R12 R2 video sweep");

        // Directed corners: first and last bytes read by the processor.
        bus(32'hFFFF_D000, 1'b1, 8'h00, 1'b1, 1'b1, rv);
        chk(rv == model[0], "R11 read low corner", rv, model[0]);
        bus(32'hFFFF_DFFF, 1'b1, 8'h00, 1'b1, 1'b1, rv);
        chk(rv == model[4095], "R11 read high corner", rv, model[4095]);

        // Keyboard writes must not reach the array.
        bus(32'hFFFF_C0F4, 1'b0, ~model[12'h0F4], 1'b0, 1'b1, rv);
        vid_check(12'h0F4, "R7 kbd data write ignored");
        bus(32'hFFFF_C0F5, 1'b0, ~model[12'h0F5], 1'b0, 1'b1, rv);
        vid_check(12'h0F5, "R7 kbd status write ignored");

        // Seeded random mixed traffic.
        for (int k = 0; k < 400; k++) begin
            int          op  = int'($urandom % 5);
            logic [11:0] ofs = 12'($urandom);
            logic [7:0]  d   = 8'($urandom);
            kbd_data = 8'($urandom); kbd_status = 8'($urandom);
            case (op)
                0: begin
                    bus(32'hFFFF_D000 + ofs, 1'b0, d, 1'b1, 1'b1, rv);
                    model[ofs] = d;
                    vid_check(ofs, "R2 R12 random write");
                end
                1: begin
                    bus(32'hFFFF_D000 + ofs, 1'b1, 8'h00, 1'b1, 1'b1, rv);
                    chk(rv == model[ofs], "R11 random read", rv, model[ofs]);
                end
                2: begin
                    logic [11:0] io = ($urandom % 3 == 0) ? 12'h0F4 :
                                      ($urandom % 2 == 0) ? 12'h0F5 : ofs;
                    logic [7:0]  ex = (io == 12'h0F4) ? kbd_data :
                                      (io == 12'h0F5) ? kbd_status : 8'h00;
                    bus(32'hFFFF_C000 + io, 1'b1, 8'h00, 1'b0, 1'b1, rv);
                    chk(rv == ex, "R6 io read", rv, ex);
                end
                3: begin
                    bus(32'hFFFF_C000 + ofs, 1'b0, d, 1'b0, 1'b1, rv);
                    vid_check(ofs, "R7 io write ignored");
                end
                default: begin
                    bus(32'hFFFF_D000 + ofs, 1'b0, ~model[ofs], 1'b1, 1'b0, rv);
                    vid_check(ofs, "R2 unselected write ignored");
                end
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule